// File: doc/BRIEF.md
# Dual-Event GPIO Edge Interrupt Controller

This block watches a parameterised set of already-debounced GPIO inputs and turns their transitions into interrupt requests. Each pin has an enable bit and a polarity bit. When a pin is enabled, an edge in the direction its polarity selects is latched as an *assert* event. An edge in the other direction is latched as a *deassert* event in a second status register. Both status registers are sticky. Each one drives its own summary interrupt line. Software that wants both-edge detection services both lines.

Software reaches the block through a plain word-wide register port. The port has a write strobe, a 4-bit address, write data, and combinational read data. `addr[3:2]` selects the register kind and `addr[1:0]` selects the word within it. The enable and polarity words each carry 32 pins. The status words carry 31 pins from bit 1 upward, and bit 0 is always zero. Software clears status by writing ones. The block has no streaming data path, so every pin is a plain control or status signal.

The expected driver sequence is to clear a pin's pending assert and deassert bits before setting its enable bit, so that an old event cannot raise a request.

Top module: `gpio_evt_irq_ctrl`

## Requirements
- R1: After reset, every enable, polarity and status bit is 0, both interrupt lines are low, and every address reads 0.
- R2: For an enabled pin whose polarity bit is 1, a 0-to-1 change sets its assert status bit, and a 1-to-0 change sets its deassert status bit. The bit is readable after the first rising clock edge that sees the new input level.
- R3: For an enabled pin whose polarity bit is 0, a 1-to-0 change sets its assert status bit, and a 0-to-1 change sets its deassert status bit.
- R4: Status registers are read and cleared with `addr[3:2]` = 2 for assert and 3 for deassert. Pin p sits in word p/31 (`addr[1:0]`) at bit (p mod 31)+1. Bit 0 of a status word always reads 0, and a write to it has no effect.
- R5: Enable (`addr[3:2]` = 0) and polarity (`addr[3:2]` = 1) are written as whole words and read back unchanged. Pin p sits in word p/32 at bit p mod 32.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it as it was.
- R7: An edge on a pin whose enable bit is 0 sets neither of its status bits.
- R8: `irq_assert` is high exactly while some assert status bit is set, and `irq_deassert` is high exactly while some deassert status bit is set.
- R9: When an edge event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Enable, polarity and status bits for pin numbers at or above NUM_PINS read as 0 whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Debounced GPIO input levels |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Register select: [3:2] kind, [1:0] word |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_assert | output | 1 | High while any assert status bit is set |
| irq_deassert | output | 1 | High while any deassert status bit is set |

## Verification
An input change or a register write is registered on the next rising clock edge. Its effect on status, readback and both interrupt lines is therefore visible one edge after the stimulus. Read data follows `addr` with no clock delay.

The bench changes inputs on the falling edge and samples the interrupt lines after the next falling edge, which is exactly one rising edge later. It reads every address a short delay after moving `addr`, while no write is active. The expected words come from an arithmetic model of the enable, polarity and status bits. The model is updated with the same one-edge delay, and an enable written in a cycle only gates edges from the following cycle onward.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int MAX_PINS = 93;
  localparam int ST_PER_W = 31;
  localparam int CF_PER_W = 32;
  localparam int PAD_W    = 4 * CF_PER_W;

  typedef enum logic [1:0] {
    REG_ENABLE   = 2'd0,
    REG_POLARITY = 2'd1,
    REG_ASSERT   = 2'd2,
    REG_DEASSERT = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
  parameter int NUM_PINS = 93
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] rise,
  output logic [NUM_PINS-1:0] fall
);

  logic [NUM_PINS-1:0] prev_q;
  logic                primed_q;

  // prev_q takes the live level every cycle; primed_q masks the first
  // cycle after reset, when prev_q does not yet hold a real sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_in;
      primed_q <= 1'b1;
    end
  end

  assign rise = {NUM_PINS{primed_q}} & pin_in & ~prev_q;
  assign fall = {NUM_PINS{primed_q}} & ~pin_in & prev_q;

endmodule

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 93
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] en_q,
  output logic [NUM_PINS-1:0] pol_q
);

  logic [NUM_PINS-1:0] en_we;
  logic [NUM_PINS-1:0] pol_we;
  logic [NUM_PINS-1:0] wbit;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [1:0] WORD = 2'(p / CF_PER_W);
    localparam int         BITN = p % CF_PER_W;
    logic hit;
    assign hit       = wr_en && (addr[1:0] == WORD);
    assign en_we[p]  = hit && (reg_kind_e'(addr[3:2]) == REG_ENABLE);
    assign pol_we[p] = hit && (reg_kind_e'(addr[3:2]) == REG_POLARITY);
    assign wbit[p]   = wdata[BITN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
    end else begin
      en_q  <= (en_q & ~en_we) | (wbit & en_we);
      pol_q <= (pol_q & ~pol_we) | (wbit & pol_we);
    end
  end

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int NUM_PINS = 93
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_v,
  input  logic [NUM_PINS-1:0] clr_v,
  output logic [NUM_PINS-1:0] st_q,
  output logic                irq
);

  // Clear is applied first, set last: a coincident event survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (st_q & ~clr_v) | set_v;
  end

  assign irq = |st_q;

endmodule

// File: rtl/gpio_evt_irq_ctrl.sv
module gpio_evt_irq_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 93
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                wr_en,
  input  logic [3:0]          addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                irq_assert,
  output logic                irq_deassert
);

  logic [NUM_PINS-1:0] rise, fall;
  logic [NUM_PINS-1:0] en_q, pol_q;
  logic [NUM_PINS-1:0] set_a, set_d, clr_a, clr_d;
  logic [NUM_PINS-1:0] st_a, st_d;

  gpio_evt_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
  );

  gpio_evt_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .en_q(en_q), .pol_q(pol_q)
  );

  assign set_a = en_q & ((pol_q & rise) | (~pol_q & fall));
  assign set_d = en_q & ((pol_q & fall) | (~pol_q & rise));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_clr
    localparam logic [1:0] WORD = 2'(p / ST_PER_W);
    localparam int         BITN = (p % ST_PER_W) + 1;
    logic hit;
    assign hit      = wr_en && (addr[1:0] == WORD) && wdata[BITN];
    assign clr_a[p] = hit && (reg_kind_e'(addr[3:2]) == REG_ASSERT);
    assign clr_d[p] = hit && (reg_kind_e'(addr[3:2]) == REG_DEASSERT);
  end

  gpio_evt_status #(.NUM_PINS(NUM_PINS)) u_st_a (
    .clk(clk), .rst_n(rst_n), .set_v(set_a), .clr_v(clr_a),
    .st_q(st_a), .irq(irq_assert)
  );

  gpio_evt_status #(.NUM_PINS(NUM_PINS)) u_st_d (
    .clk(clk), .rst_n(rst_n), .set_v(set_d), .clr_v(clr_d),
    .st_q(st_d), .irq(irq_deassert)
  );

  // Readback: zero-padded flat vectors, so pins past NUM_PINS read 0.
  logic [PAD_W-1:0] en_pad, pol_pad, sa_pad, sd_pad;
  logic [6:0]       base_cf, base_st;

  assign en_pad  = PAD_W'(en_q);
  assign pol_pad = PAD_W'(pol_q);
  assign sa_pad  = PAD_W'(st_a);
  assign sd_pad  = PAD_W'(st_d);
  assign base_cf = {addr[1:0], 5'd0};
  assign base_st = 7'({5'd0, addr[1:0]}) * 7'd31;

  always_comb begin
    unique case (reg_kind_e'(addr[3:2]))
      REG_ENABLE:   rdata = en_pad[base_cf +: 32];
      REG_POLARITY: rdata = pol_pad[base_cf +: 32];
      REG_ASSERT:   rdata = {sa_pad[base_st +: 31], 1'b0};
      default:      rdata = {sd_pad[base_st +: 31], 1'b0};
    endcase
  end

endmodule

// File: rtl/gpio_evt_irq_chk.sv
module gpio_evt_irq_chk #(
  parameter int NUM_PINS = 93
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [3:0]          addr,
  input logic [31:0]         rdata,
  input logic                irq_assert,
  input logic                irq_deassert,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] st_a,
  input logic [NUM_PINS-1:0] st_d,
  input logic [NUM_PINS-1:0] set_a,
  input logic [NUM_PINS-1:0] clr_a
);

  AST_ASSERT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_a & ~$past(st_a) & ~$past(en_q)) == '0)); // R7

  AST_DEASSERT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_d & ~$past(st_d) & ~$past(en_q)) == '0)); // R7

  AST_STICKY_UNTIL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(st_a) & ~$past(clr_a) & ~st_a) == '0)); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_a & clr_a) & ~st_a) == '0)); // R9

  AST_IRQ_RISE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_assert) |-> ($past(en_q) != '0)); // R8

  AST_IRQ_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_deassert) |-> $past(wr_en)); // R8

  AST_STATUS_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr[3] |-> (rdata[0] == 1'b0)); // R4

endmodule

bind gpio_evt_irq_ctrl gpio_evt_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .irq_assert(irq_assert), .irq_deassert(irq_deassert),
  .en_q(en_q), .st_a(st_a), .st_d(st_d), .set_a(set_a), .clr_a(clr_a)
);

// File: tb/sim_gpio_evt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_evt_irq_ctrl;

  localparam int NP = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = 4'd0;
  logic [31:0]   wdata = 32'd0;
  logic [31:0]   rdata;
  logic          irq_assert, irq_deassert;

  logic [NP-1:0] m_en = '0, m_pol = '0, m_a = '0, m_d = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_evt_irq_ctrl #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_assert(irq_assert),
    .irq_deassert(irq_deassert)
  );

  function automatic logic [31:0] exp_word(input logic [3:0] a);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int p;
      if (a[3] == 1'b0) begin
        p = int'(a[1:0]) * 32 + b;
        if (p < NP) r[b] = (a[2] == 1'b0) ? m_en[p] : m_pol[p];
      end else if (b > 0) begin
        p = int'(a[1:0]) * 31 + b - 1;
        if (p < NP) r[b] = (a[2] == 1'b0) ? m_a[p] : m_d[p];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " irq_assert"}, 32'(irq_assert), 32'(m_a != '0));
    check({req, " irq_deassert"}, 32'(irq_deassert), 32'(m_d != '0));
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #1;
      check($sformatf("%s addr %0d", req, a), rdata, exp_word(4'(a)));
    end
  endtask

  // Drives one cycle of stimulus at a falling edge; the model follows
  // the one-edge latency and uses the enables in force before the write.
  task automatic apply(input logic [NP-1:0] np, input logic w,
                       input logic [3:0] a, input logic [31:0] d);
    logic [NP-1:0] rs, fl, sa, sd, ca, cd;
    @(negedge clk);
    rs = np & ~pins;
    fl = ~np & pins;
    sa = m_en & ((m_pol & rs) | (~m_pol & fl));
    sd = m_en & ((m_pol & fl) | (~m_pol & rs));
    ca = '0;
    cd = '0;
    for (int p = 0; p < NP; p++) begin
      if (w && a[1:0] == 2'(p / 31) && d[p % 31 + 1]) begin
        if (a[3:2] == 2'd2) ca[p] = 1'b1;
        if (a[3:2] == 2'd3) cd[p] = 1'b1;
      end
      if (w && a[1:0] == 2'(p / 32)) begin
        if (a[3:2] == 2'd0) m_en[p]  = d[p % 32];
        if (a[3:2] == 2'd1) m_pol[p] = d[p % 32];
      end
    end
    m_a = (m_a & ~ca) | sa;
    m_d = (m_d & ~cd) | sd;
    pins = np; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    logic [NP-1:0] en_want, pol_want;
    for (int p = 0; p < NP; p++) begin
      pins[p]     = (p % 3 == 0);
      en_want[p]  = (p % 5 != 4);
      pol_want[p] = (p % 2 == 1);
    end
    repeat (3) @(negedge clk);
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 R10");

    // R5 / R10: whole-word writes, ones in bits that map past NP.
    apply(pins, 1'b1, 4'b0000, en_want[31:0]);
    apply(pins, 1'b1, 4'b0001, {24'hFFFFFF, en_want[39:32]});
    apply(pins, 1'b1, 4'b0010, 32'hFFFF_FFFF);
    apply(pins, 1'b1, 4'b0100, pol_want[31:0]);
    apply(pins, 1'b1, 4'b0101, {24'hFFFFFF, pol_want[39:32]});
    apply(pins, 1'b1, 4'b0111, 32'hFFFF_FFFF);
    check_all("R5 R10");

    // R2 R3 R4 R7 R8: each pin toggled both ways, one at a time.
    for (int p = 0; p < NP; p++) begin
      logic [NP-1:0] np;
      np = pins; np[p] = ~np[p];
      apply(np, 1'b0, 4'd0, 32'd0);
      check_all("R2 R3 R4 R7 R8");
      np[p] = ~np[p];
      apply(np, 1'b0, 4'd0, 32'd0);
      check_all("R2 R3 R4 R7 R8");
    end

    // R6: zero writes and bit-0 writes change nothing (R4).
    apply(pins, 1'b1, 4'b1000, 32'd0);
    apply(pins, 1'b1, 4'b1101, 32'd1);
    check_all("R6 R4");
    apply(pins, 1'b1, 4'b1000, 32'hFFFF_FFFF);
    apply(pins, 1'b1, 4'b1101, 32'h0000_0154);
    check_all("R6 R8");
    apply(pins, 1'b1, 4'b1001, 32'hFFFF_FFFF);
    apply(pins, 1'b1, 4'b1100, 32'hFFFF_FFFF);
    apply(pins, 1'b1, 4'b1101, 32'hFFFF_FFFF);
    check_all("R6 R8");

    // Many pins at once.
    apply(pins ^ 40'h5A_5A5A_5A5A, 1'b0, 4'd0, 32'd0);
    check_all("R2 R3 R7");

    // R9: edge on pin 2 while clearing its assert word; pin 33 deassert word.
    begin
      logic [NP-1:0] np;
      np = pins; np[2] = ~np[2]; np[33] = ~np[33];
      apply(np, 1'b1, 4'b1000, 32'hFFFF_FFFF);
      check_all("R9");
      np[2] = ~np[2];
      apply(np, 1'b1, 4'b1100, 32'hFFFF_FFFF);
      check_all("R9");
      np[33] = ~np[33];
      apply(np, 1'b1, 4'b1101, 32'hFFFF_FFFF);
      check_all("R9");
    end

    // R7: all enables off, then toggle everything.
    apply(pins, 1'b1, 4'b1000, 32'hFFFF_FFFF);
    apply(pins, 1'b1, 4'b1001, 32'hFFFF_FFFF);
    apply(pins, 1'b1, 4'b1100, 32'hFFFF_FFFF);
    apply(pins, 1'b1, 4'b1101, 32'hFFFF_FFFF);
    apply(pins, 1'b1, 4'b0000, 32'd0);
    apply(pins, 1'b1, 4'b0001, 32'd0);
    apply(~pins, 1'b0, 4'd0, 32'd0);
    apply(~pins, 1'b0, 4'd0, 32'd0);
    check_all("R7 R8");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule